// File: doc/BRIEF.md
# LCD Vertical Timing and Colour Gating Controller

This block produces the vertical frame timing for an LCD panel with 18-bit RGB output. A line counter advances on a per-line tick from the horizontal timing logic. It walks through four frame phases in a fixed order: sync pulse, back porch, active video and front porch. The length of each phase, in lines, is set through an input port. A compare select field picks one of the four phase starts. At that point the block raises a one-cycle vertical compare interrupt and sets a sticky status flag.

The block also gates the three 6-bit colour channels between a pixel data input and the panel outputs. The gate uses a two-step enable: the control-signal enable must already be on before a data power enable is accepted. Finally, the block asks a pixel FIFO for more data when the FIFO reports enough free slots. The threshold is either 4 or 8 free slots, chosen by a watermark bit.

Software uses two 32-bit words. Word 0 is the control word and word 1 is the interrupt status. `reg_addr` selects the word, for both writes and the combinational read-back.

Top module: `lcd_vt_ctrl`

## Requirements
- R1: After synchronous reset, the control word and the status word read 0, all colour outputs are 0, `fifo_rd_req` is 0, `frame_phase` is 0 and `vcmp_irq` is 0.
- R2: The control word holds enable in bit 0, data power enable in bit 11, compare select in bits 13:12 and watermark in bit 16. Every other bit reads 0 whatever is written, and the status word reads 0 in bits 31:1.
- R3: While enable is 1, each `line_tick` adds one line. The phase codes run 0 (sync), 1 (back porch), 2 (active), 3 (front porch), then back to 0. Each phase lasts its length input in lines, and a length of 0 counts as 1. While enable is 0, the phase is held at 0 with the line count at the start.
- R4: `vcmp_irq` is high for exactly the one cycle in which `frame_phase` first shows the phase whose code equals the compare select. That cycle is the cycle after the clock edge that took the tick. Entry into phase 0 when enable rises does not raise it.
- R5: Status bit 0 becomes 1 with each interrupt pulse and stays 1. Writing 1 to status bit 0 clears it, writing 0 leaves it, and a pulse in the same cycle as a clear wins.
- R6: When both enable and data power enable are 1, the outputs follow `pix_data`: red is bits 17:12, green is bits 11:6 and blue is bits 5:0. Otherwise all three outputs are 0.
- R7: A write takes data power enable as 1 only if enable was already 1 before the write and the same write keeps enable at 1. Setting both bits in one write from the disabled state leaves data power enable at 0.
- R8: A control write that clears enable also clears data power enable. The colour outputs are 0 from the cycle after that write.
- R9: One cycle after `fifo_free` is sampled, `fifo_rd_req` is 1 when enable is 1 and `fifo_free` is at least 4 (watermark 0) or at least 8 (watermark 1).
- R10: While enable is 0, `fifo_rd_req` is 0 for any `fifo_free` value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Word select: 0 control, 1 status |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected word (combinational) |
| line_tick | input | 1 | One-cycle pulse per display line |
| len_sync | input | 10 | Sync pulse length in lines |
| len_back | input | 10 | Back porch length in lines |
| len_active | input | 10 | Active video length in lines |
| len_front | input | 10 | Front porch length in lines |
| frame_phase | output | 2 | Current phase code |
| vcmp_irq | output | 1 | Vertical compare interrupt pulse |
| pix_data | input | 18 | Pixel word from the FIFO |
| fifo_free | input | 5 | Number of empty FIFO slots |
| fifo_rd_req | output | 1 | Refill request to the FIFO |
| lcd_r | output | 6 | Red output |
| lcd_g | output | 6 | Green output |
| lcd_b | output | 6 | Blue output |

## Verification
A control write is visible in the read-back and in the colour gating at the first falling edge after the edge that takes it. A line tick shows up in `frame_phase` and `vcmp_irq` one edge later, and the interrupt must be gone one edge after that. `fifo_rd_req` is registered, so it answers a `fifo_free` value one edge after that value is sampled. The bench drives every stimulus on a falling edge and checks at the following falling edge, or at the second one for the interrupt drop. The expected phase and interrupt come from the tick count modulo the frame length, and the expected request from a direct compare against 4 or 8.

// File: rtl/lcd_vt_pkg.sv
package lcd_vt_pkg;

    typedef enum logic [1:0] {
        PH_SYNC   = 2'd0,
        PH_BACK   = 2'd1,
        PH_ACTIVE = 2'd2,
        PH_FRONT  = 2'd3
    } vphase_e;

    typedef struct packed {
        logic       wm;
        logic [1:0] vsel;
        logic       pwr;
        logic       en;
    } ctl_t;

    localparam int EN_BIT  = 0;
    localparam int PWR_BIT = 11;
    localparam int SEL_LO  = 12;
    localparam int SEL_HI  = 13;
    localparam int WM_BIT  = 16;

    localparam int FREE_LOW  = 4;
    localparam int FREE_HIGH = 8;

    function automatic logic [31:0] pack_ctl(ctl_t c);
        logic [31:0] w;
        w                 = '0;
        w[EN_BIT]         = c.en;
        w[PWR_BIT]        = c.pwr;
        w[SEL_HI:SEL_LO]  = c.vsel;
        w[WM_BIT]         = c.wm;
        return w;
    endfunction

    function automatic vphase_e next_phase(vphase_e p);
        case (p)
            PH_SYNC:   return PH_BACK;
            PH_BACK:   return PH_ACTIVE;
            PH_ACTIVE: return PH_FRONT;
            default:   return PH_SYNC;
        endcase
    endfunction

    function automatic int free_threshold(logic wm);
        return wm ? FREE_HIGH : FREE_LOW;
    endfunction

endpackage

// File: rtl/lcd_vt_regs.sv
module lcd_vt_regs
    import lcd_vt_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr,
    input  logic        addr,
    input  logic [31:0] wdata,
    input  logic        irq_pulse,
    output ctl_t        ctl,
    output logic        stat,
    output logic [31:0] rdata
);

    ctl_t ctl_q;
    logic stat_q;
    logic unused_wbits;

    assign unused_wbits = ^{wdata[31:17], wdata[15:14], wdata[10:1]};

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q  <= '0;
            stat_q <= 1'b0;
        end else begin
            if (wr && !addr) begin
                ctl_q.en   <= wdata[EN_BIT];
                // data power accepted only on top of an existing enable
                ctl_q.pwr  <= wdata[PWR_BIT] & wdata[EN_BIT] & ctl_q.en;
                ctl_q.vsel <= wdata[SEL_HI:SEL_LO];
                ctl_q.wm   <= wdata[WM_BIT];
            end
            if (irq_pulse)
                stat_q <= 1'b1;
            else if (wr && addr && wdata[0])
                stat_q <= 1'b0;
        end
    end

    always_comb begin
        if (addr)
            rdata = {31'b0, stat_q};
        else
            rdata = pack_ctl(ctl_q);
    end

    assign ctl  = ctl_q;
    assign stat = stat_q;

endmodule

// File: rtl/lcd_vt_frame.sv
module lcd_vt_frame
    import lcd_vt_pkg::*;
#(
    parameter int LINE_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              line_tick,
    input  logic [1:0]        sel,
    input  logic [LINE_W-1:0] len_sync,
    input  logic [LINE_W-1:0] len_back,
    input  logic [LINE_W-1:0] len_active,
    input  logic [LINE_W-1:0] len_front,
    output logic [1:0]        phase,
    output logic              irq
);

    localparam int CW = LINE_W + 1;

    vphase_e           phase_q;
    vphase_e           phase_nx;
    logic [LINE_W-1:0] cnt_q;
    logic [LINE_W-1:0] cur_len;
    logic              at_end;
    logic              irq_q;

    always_comb begin
        case (phase_q)
            PH_SYNC:   cur_len = len_sync;
            PH_BACK:   cur_len = len_back;
            PH_ACTIVE: cur_len = len_active;
            default:   cur_len = len_front;
        endcase
        // zero length behaves as one line
        at_end   = (CW'(cnt_q) + CW'(1)) >= CW'(cur_len);
        phase_nx = next_phase(phase_q);
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            phase_q <= PH_SYNC;
            cnt_q   <= '0;
            irq_q   <= 1'b0;
        end else begin
            irq_q <= 1'b0;
            if (line_tick) begin
                if (at_end) begin
                    phase_q <= phase_nx;
                    cnt_q   <= '0;
                    irq_q   <= (phase_nx == vphase_e'(sel));
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign phase = phase_q;
    assign irq   = irq_q;

endmodule

// File: rtl/lcd_vt_pixgate.sv
module lcd_vt_pixgate
    import lcd_vt_pkg::*;
#(
    parameter int COLOR_W = 6,
    parameter int SLOT_W  = 5
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  logic                 pwr,
    input  logic                 wm,
    input  logic [3*COLOR_W-1:0] pix_data,
    input  logic [SLOT_W-1:0]    free_slots,
    output logic [COLOR_W-1:0]   out_r,
    output logic [COLOR_W-1:0]   out_g,
    output logic [COLOR_W-1:0]   out_b,
    output logic                 rd_req
);

    localparam int NCH = 3;

    logic                data_on;
    logic [COLOR_W-1:0]  chan [NCH];
    logic                req_q;
    logic [SLOT_W:0]     thresh;

    assign data_on = en & pwr;

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        assign chan[c] = data_on ? pix_data[c*COLOR_W +: COLOR_W] : '0;
    end

    assign out_b = chan[0];
    assign out_g = chan[1];
    assign out_r = chan[2];

    assign thresh = (SLOT_W+1)'(free_threshold(wm));

    always_ff @(posedge clk) begin
        if (rst)
            req_q <= 1'b0;
        else
            req_q <= en && ({1'b0, free_slots} >= thresh);
    end

    assign rd_req = req_q;

endmodule

// File: rtl/lcd_vt_ctrl.sv
module lcd_vt_ctrl
    import lcd_vt_pkg::*;
#(
    parameter int LINE_W     = 10,
    parameter int COLOR_W    = 6,
    parameter int FIFO_DEPTH = 16,
    localparam int SLOT_W    = $clog2(FIFO_DEPTH + 1),
    localparam int PIX_W     = 3 * COLOR_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_wr,
    input  logic               reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    input  logic               line_tick,
    input  logic [LINE_W-1:0]  len_sync,
    input  logic [LINE_W-1:0]  len_back,
    input  logic [LINE_W-1:0]  len_active,
    input  logic [LINE_W-1:0]  len_front,
    output logic [1:0]         frame_phase,
    output logic               vcmp_irq,
    input  logic [PIX_W-1:0]   pix_data,
    input  logic [SLOT_W-1:0]  fifo_free,
    output logic               fifo_rd_req,
    output logic [COLOR_W-1:0] lcd_r,
    output logic [COLOR_W-1:0] lcd_g,
    output logic [COLOR_W-1:0] lcd_b
);

    ctl_t       ctl;
    logic       stat_q;
    logic       ctl_en;
    logic       ctl_pwr;
    logic [1:0] ctl_sel;

    assign ctl_en  = ctl.en;
    assign ctl_pwr = ctl.pwr;
    assign ctl_sel = ctl.vsel;

    lcd_vt_regs i_regs (
        .clk       (clk),
        .rst       (rst),
        .wr        (reg_wr),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .irq_pulse (vcmp_irq),
        .ctl       (ctl),
        .stat      (stat_q),
        .rdata     (reg_rdata)
    );

    lcd_vt_frame #(.LINE_W(LINE_W)) i_frame (
        .clk        (clk),
        .rst        (rst),
        .en         (ctl.en),
        .line_tick  (line_tick),
        .sel        (ctl.vsel),
        .len_sync   (len_sync),
        .len_back   (len_back),
        .len_active (len_active),
        .len_front  (len_front),
        .phase      (frame_phase),
        .irq        (vcmp_irq)
    );

    lcd_vt_pixgate #(.COLOR_W(COLOR_W), .SLOT_W(SLOT_W)) i_pix (
        .clk        (clk),
        .rst        (rst),
        .en         (ctl.en),
        .pwr        (ctl.pwr),
        .wm         (ctl.wm),
        .pix_data   (pix_data),
        .free_slots (fifo_free),
        .out_r      (lcd_r),
        .out_g      (lcd_g),
        .out_b      (lcd_b),
        .rd_req     (fifo_rd_req)
    );

endmodule

// File: rtl/lcd_vt_checker.sv
module lcd_vt_checker #(
    parameter int COLOR_W = 6
) (
    input logic               clk,
    input logic               rst,
    input logic               en,
    input logic               pwr,
    input logic [1:0]         sel,
    input logic [1:0]         phase,
    input logic               irq,
    input logic               stat,
    input logic [COLOR_W-1:0] out_r,
    input logic [COLOR_W-1:0] out_g,
    input logic [COLOR_W-1:0] out_b,
    input logic               rd_req
);

    AST_PHASE_ORDER: assert property (@(posedge clk) disable iff (rst)
        (phase != $past(phase)) |-> (phase == 2'($past(phase) + 2'd1) || phase == 2'd0)); // R3

    AST_IRQ_AT_SELECTED: assert property (@(posedge clk) disable iff (rst)
        irq |-> (phase == $past(sel) && phase != $past(phase) && $past(en))); // R4

    AST_IRQ_SETS_STATUS: assert property (@(posedge clk) disable iff (rst)
        irq |=> stat); // R5

    AST_GATED_LOW: assert property (@(posedge clk) disable iff (rst)
        (!en || !pwr) |-> (out_r == '0 && out_g == '0 && out_b == '0)); // R6

    AST_PWR_AFTER_EN: assert property (@(posedge clk) disable iff (rst)
        $rose(pwr) |-> $past(en)); // R7

    AST_EN_DROP_KILLS_PWR: assert property (@(posedge clk) disable iff (rst)
        $fell(en) |-> !pwr); // R8

    AST_NO_REQ_DISABLED: assert property (@(posedge clk) disable iff (rst)
        !$past(en) |-> !rd_req); // R10

endmodule

bind lcd_vt_ctrl lcd_vt_checker #(.COLOR_W(COLOR_W)) i_chk (
    .clk    (clk),
    .rst    (rst),
    .en     (ctl_en),
    .pwr    (ctl_pwr),
    .sel    (ctl_sel),
    .phase  (frame_phase),
    .irq    (vcmp_irq),
    .stat   (stat_q),
    .out_r  (lcd_r),
    .out_g  (lcd_g),
    .out_b  (lcd_b),
    .rd_req (fifo_rd_req)
);

// File: tb/test_lcd_vt_ctrl.sv
`timescale 1ns/1ps
module test_lcd_vt_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic        reg_addr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        line_tick = 1'b0;
    logic [9:0]  len_sync = 10'd1, len_back = 10'd1, len_active = 10'd1, len_front = 10'd1;
    logic [1:0]  frame_phase;
    logic        vcmp_irq;
    logic [17:0] pix_data = 18'h2D5A3;
    logic [4:0]  fifo_free = '0;
    logic        fifo_rd_req;
    logic [5:0]  lcd_r, lcd_g, lcd_b;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    lcd_vt_ctrl i_lcd_vt_ctrl (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .line_tick(line_tick),
        .len_sync(len_sync), .len_back(len_back), .len_active(len_active),
        .len_front(len_front), .frame_phase(frame_phase), .vcmp_irq(vcmp_irq),
        .pix_data(pix_data), .fifo_free(fifo_free), .fifo_rd_req(fifo_rd_req),
        .lcd_r(lcd_r), .lcd_g(lcd_g), .lcd_b(lcd_b)
    );

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic reg_write(logic a, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic reg_read(logic a, output logic [31:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    task automatic check_colour(string req, bit on);
        #0.5;
        check(req, lcd_r, on ? int'(pix_data[17:12]) : 0);
        check(req, lcd_g, on ? int'(pix_data[11:6])  : 0);
        check(req, lcd_b, on ? int'(pix_data[5:0])   : 0);
    endtask

    function automatic int eff(int l);
        return (l == 0) ? 1 : l;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        int lens [3][4] = '{'{1, 2, 3, 2}, '{0, 1, 2, 1}, '{2, 1, 1, 3}};

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        reg_read(1'b0, rd); check("R1 ctl", rd, 0);
        reg_read(1'b1, rd); check("R1 stat", rd, 0);
        check_colour("R1 colour", 0);
        check("R1 req", fifo_rd_req, 0);
        check("R1 phase", frame_phase, 0);
        check("R1 irq", vcmp_irq, 0);

        // R2 / R7 field map and interlock
        reg_write(1'b0, 32'hFFFF_FFFF);
        reg_read(1'b0, rd); check("R2 R7 all-ones from off", rd, 32'h0001_3001);
        check_colour("R7 same-write stays dark", 0);
        reg_write(1'b0, 32'hFFFF_FFFF);
        reg_read(1'b0, rd); check("R2 all-ones with en set", rd, 32'h0001_3801);
        reg_write(1'b1, 32'hFFFF_FFFE);
        reg_read(1'b1, rd); check("R2 stat reserved", rd, 0);

        // R6 colour passthrough patterns
        for (int k = 0; k < 8; k++) begin
            pix_data = 18'((k * 32'h9A5B3 + 32'h1234) & 32'h3FFFF);
            check_colour("R6 passthrough", 1);
        end

        // R8 dropping enable kills data and power bit
        reg_write(1'b0, 32'h0000_0800);
        reg_read(1'b0, rd); check("R8 pwr cleared", rd, 0);
        check_colour("R8 dark after en drop", 0);
        reg_write(1'b0, 32'h0000_0001);
        check_colour("R6 en without pwr dark", 0);
        reg_write(1'b0, 32'h0000_0801);
        check_colour("R7 pwr after en lit", 1);
        reg_write(1'b0, 32'h0000_0000);

        // R3 hold while disabled
        for (int k = 0; k < 3; k++) begin
            @(negedge clk); line_tick = 1'b1;
            @(negedge clk); line_tick = 1'b0;
            check("R3 hold disabled", frame_phase, 0);
            check("R4 no irq disabled", vcmp_irq, 0);
        end

        // R3 R4 R5 frame sweep
        for (int s = 0; s < 3; s++) begin
            for (int sel = 0; sel < 4; sel++) begin
                int b1, b2, b3, fr, start;
                int st [4];
                b1 = eff(lens[s][0]);
                b2 = b1 + eff(lens[s][1]);
                b3 = b2 + eff(lens[s][2]);
                fr = b3 + eff(lens[s][3]);
                st = '{0, b1, b2, b3};
                start = st[sel];
                reg_write(1'b0, 32'h0);
                reg_write(1'b1, 32'h1);
                len_sync = 10'(lens[s][0]); len_back = 10'(lens[s][1]);
                len_active = 10'(lens[s][2]); len_front = 10'(lens[s][3]);
                reg_write(1'b0, 32'h1 | (32'(sel) << 12));
                check("R4 no irq on enable", vcmp_irq, 0);
                for (int k = 1; k <= 2 * fr + 1; k++) begin
                    int n, ep;
                    n = k % fr;
                    ep = (n < b1) ? 0 : (n < b2) ? 1 : (n < b3) ? 2 : 3;
                    @(negedge clk); line_tick = 1'b1;
                    @(negedge clk); line_tick = 1'b0;
                    check("R3 phase", frame_phase, ep);
                    check("R4 irq", vcmp_irq, (n == start) ? 1 : 0);
                    @(negedge clk);
                    check("R4 irq one cycle", vcmp_irq, 0);
                    check("R3 phase holds", frame_phase, ep);
                end
                reg_read(1'b1, rd); check("R5 sticky", rd, 1);
                reg_write(1'b1, 32'h0);
                reg_read(1'b1, rd); check("R5 write 0 keeps", rd, 1);
                reg_write(1'b1, 32'h1);
                reg_read(1'b1, rd); check("R5 write 1 clears", rd, 0);
            end
        end

        // R9 R10 refill request sweep
        for (int e = 0; e < 2; e++) begin
            for (int w = 0; w < 2; w++) begin
                reg_write(1'b0, 32'(e) | (32'(w) << 16));
                for (int f = 0; f <= 16; f++) begin
                    int exp;
                    exp = (e == 1 && f >= (w ? 8 : 4)) ? 1 : 0;
                    fifo_free = 5'(f);
                    @(negedge clk);
                    if (e == 1) check("R9 refill", fifo_rd_req, exp);
                    else        check("R10 refill disabled", fifo_rd_req, 0);
                end
            end
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule